// File: doc/BRIEF.md
# Buffered Serial Flash Page Programmer

This block programs one page of a serial flash device over a single data lane. Control software fills a 128-byte staging buffer through a 32-bit data port, loads the program opcode and a three- or four-byte target address into byte registers, and sets a go bit in the command register. The engine then drives a framed transfer: opcode, address and all 128 page bytes go out on one line. When the transfer ends, the go bit clears itself and the buffer fill pointer returns to zero.

The staging buffer has its own enable. Turning it on or off is a handshake. Software writes the requested value into a configuration bit and waits until a readback bit shows the new value. The readback follows the request after a fixed settling delay. When the readback shows the buffer as off, the same go bit sends a short frame instead: opcode, address and a single byte taken from a one-byte write-data register.

Software drives the block through a simple write-only register port. Every register write is one cycle with `reg_we` high. Busy, the buffer-enable readback and the fill level come out as dedicated status outputs.

Top module: `spp_page_programmer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `cmd_busy` is 0, `bufen_status` is 0 and `fill_words` is 0.
- R2: Register 1 bit 0 requests the buffer mode. `bufen_status` takes the requested value exactly `ACK_LAT` (default 4) cycles after the write edge. The engine uses the readback value, not the request.
- R3: With the buffer on, each write to register 9 appends one 32-bit word. Bits 7:0 become the lowest-numbered byte of the four it supplies. `fill_words` counts the words held.
- R4: A buffered frame holds opcode (register 2), then the address most significant byte first, then 128 data bytes in buffer order from byte 0. Every byte is sent MSB first on `spi_mosi` and is valid at the rising edge of `spi_sck`. Each bit lasts two clock cycles: `spi_sck` is low for one and high for one.
- R5: Register 7 bit 4 selects four address bytes, taken from registers 6, 5, 4, 3 in that order. When that bit is clear, three bytes are sent (registers 5, 4, 3) and register 6 is not sent.
- R6: Writing register 0 with bit 4 set while idle starts a frame. `cmd_busy` reads 1 and `spi_cs_n` reads 0 from the next cycle on. Both return to idle after the last bit. A command write during a frame, including its final cycle, is ignored.
- R7: When `bufen_status` is 0, the go bit sends opcode, address and exactly one data byte taken from register 8 bits 7:0.
- R8: Page-port writes are dropped once 32 words are held, while `bufen_status` is 0, and while `cmd_busy` is 1.
- R9: Buffer bytes beyond the words written go out as 0x00.
- R10: The fill pointer reads 0 after every frame. A page-port write in the final frame cycle is dropped rather than counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| cmd_busy | output | 1 | Go bit readback, 1 while a frame runs |
| bufen_status | output | 1 | Acknowledged buffer-mode readback |
| fill_words | output | 6 | Number of 32-bit words buffered |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
The completion of a frame and a page-port write can land in the same cycle. In that cycle the fill pointer is cleared while a word is offered for storage. The bench holds the page-port write asserted every cycle across the end of a long buffered frame. Before each edge it samples `cmd_busy` and predicts which writes must be taken: only those at edges where the engine was already idle. It then compares that count with `fill_words`. A command write issued mid-frame is checked at the same time, by showing that exactly one frame's worth of bits reached the serial line.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam logic [3:0] RA_CMD  = 4'd0;
  localparam logic [3:0] RA_CFG  = 4'd1;
  localparam logic [3:0] RA_OPC  = 4'd2;
  localparam logic [3:0] RA_AD0  = 4'd3;
  localparam logic [3:0] RA_MODE = 4'd7;
  localparam logic [3:0] RA_WDAT = 4'd8;
  localparam logic [3:0] RA_PAGE = 4'd9;

  localparam int GO_BIT   = 4;
  localparam int BUF_BIT  = 0;
  localparam int WIDE_BIT = 4;
  localparam int ADDR_BYTES_MAX = 4;

  typedef struct packed {
    logic buffered;
    logic wide;
  } frame_cfg_t;
endpackage

// File: rtl/spp_regs.sv
module spp_regs
  import spp_pkg::*;
#(
  parameter int ACK_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [7:0]  opcode,
  output logic [ADDR_BYTES_MAX*8-1:0] addr_bytes,
  output logic        wide,
  output logic [7:0]  single_byte,
  output logic        buf_ack,
  output logic        go,
  output logic        push,
  output logic [31:0] push_word
);
  localparam int CW = $clog2(ACK_LAT + 1);

  logic [7:0]    opc_q, opc_d, sb_q, sb_d;
  logic          wide_q, wide_d, req_q, req_d, ack_q, ack_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    opc_d  = opc_q;
    sb_d   = sb_q;
    wide_d = wide_q;
    req_d  = req_q;
    ack_d  = ack_q;
    cnt_d  = '0;
    if (we) begin
      case (addr)
        RA_OPC:  opc_d  = wdata[7:0];
        RA_WDAT: sb_d   = wdata[7:0];
        RA_MODE: wide_d = wdata[WIDE_BIT];
        RA_CFG:  req_d  = wdata[BUF_BIT];
        default: ;
      endcase
    end
    if (req_q != ack_q) begin
      if (cnt_q == CW'(ACK_LAT - 1)) begin
        ack_d = req_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      sb_q   <= '0;
      wide_q <= 1'b0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      opc_q  <= opc_d;
      sb_q   <= sb_d;
      wide_q <= wide_d;
      req_q  <= req_d;
      ack_q  <= ack_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < ADDR_BYTES_MAX; g++) begin : g_abyte
    logic [7:0] ab_q;
    logic       ab_en;
    assign ab_en = we && (addr == RA_AD0 + 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ab_q <= '0;
      else if (ab_en) ab_q <= wdata[7:0];
    end
    assign addr_bytes[g*8 +: 8] = ab_q;
  end

  assign opcode      = opc_q;
  assign single_byte = sb_q;
  assign wide        = wide_q;
  assign buf_ack     = ack_q;
  assign go          = we && (addr == RA_CMD) && wdata[GO_BIT];
  assign push        = we && (addr == RA_PAGE);
  assign push_word   = wdata;

  // R2: readback only moves toward the value that was requested
  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_q) |-> ack_q == $past(req_q));
endmodule

// File: rtl/spp_pagebuf.sv
module spp_pagebuf #(
  parameter int WORD_W     = 32,
  parameter int PAGE_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [WORD_W-1:0]     push_word,
  input  logic                  clear,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [$clog2(PAGE_BYTES/(WORD_W/8)+1)-1:0] fill,
  output logic [7:0]            rd_byte
);
  localparam int LANES = WORD_W / 8;
  localparam int WORDS = PAGE_BYTES / LANES;
  localparam int FW    = $clog2(WORDS + 1);
  localparam int WIW   = $clog2(WORDS);
  localparam int LW    = $clog2(LANES);
  localparam int IW    = $clog2(PAGE_BYTES);

  logic [FW-1:0]     fill_q, fill_d;
  logic              accept;
  logic [WORD_W-1:0] mem [WORDS];
  logic [WIW-1:0]    rd_w;
  logic [LW-1:0]     rd_l;

  assign accept = push && (fill_q < FW'(WORDS)) && !clear;

  always_comb begin
    fill_d = fill_q;
    if (clear)       fill_d = '0;
    else if (accept) fill_d = fill_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic wen;
    assign wen = accept && (fill_q[WIW-1:0] == WIW'(g));
    always_ff @(posedge clk) begin
      if (wen) mem[g] <= push_word;
    end
  end

  assign rd_w    = rd_idx[IW-1:LW];
  assign rd_l    = rd_idx[LW-1:0];
  assign rd_byte = (FW'(rd_w) < fill_q) ? mem[rd_w][rd_l*8 +: 8] : 8'h00;
  assign fill    = fill_q;

  // R8: fill level never passes the page size
  a_r8_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(WORDS));
  // R10: a clear request always wins over a simultaneous push
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fill_q == '0);
endmodule

// File: rtl/spp_shifter.sv
module spp_shifter
  import spp_pkg::*;
#(
  parameter int PAGE_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  frame_cfg_t cfg_in,
  input  logic [7:0] byte_in,
  output logic       active,
  output frame_cfg_t cfg,
  output logic [$clog2(PAGE_BYTES+ADDR_BYTES_MAX+2)-1:0] byte_idx,
  output logic       done,
  output logic       cs_n,
  output logic       sck,
  output logic       mosi
);
  localparam int LENW = $clog2(PAGE_BYTES + ADDR_BYTES_MAX + 2);

  logic            act_q, act_d, ph_q, ph_d;
  logic [2:0]      bit_q, bit_d;
  logic [LENW-1:0] idx_q, idx_d, len;
  frame_cfg_t      cfg_q, cfg_d;
  logic            last_byte;

  assign len = LENW'(1) + (cfg_q.wide ? LENW'(4) : LENW'(3))
             + (cfg_q.buffered ? LENW'(PAGE_BYTES) : LENW'(1));
  assign last_byte = (idx_q == len - LENW'(1));
  assign done = act_q && ph_q && (bit_q == 3'd7) && last_byte;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    idx_d = idx_q;
    cfg_d = cfg_q;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        ph_d  = 1'b0;
        bit_d = '0;
        idx_d = '0;
        cfg_d = cfg_in;
      end
    end else begin
      ph_d = !ph_q;
      if (ph_q) begin
        if (bit_q == 3'd7) begin
          bit_d = '0;
          if (last_byte) act_d = 1'b0;
          else           idx_d = idx_q + LENW'(1);
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      bit_q <= '0;
      idx_q <= '0;
      cfg_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
      cfg_q <= cfg_d;
    end
  end

  assign active   = act_q;
  assign cfg      = cfg_q;
  assign byte_idx = idx_q;
  assign cs_n     = !act_q;
  assign sck      = act_q && ph_q;
  assign mosi     = act_q && byte_in[3'd7 - bit_q];

  // R6: once started, the frame runs until its last bit
  a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !done |=> act_q);
  // R4: data line holds steady through the high half of each bit
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |-> $stable(mosi));
endmodule

// File: rtl/spp_page_programmer.sv
module spp_page_programmer
  import spp_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PAGE_BYTES = 128,
  parameter int ACK_LAT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic        cmd_busy,
  output logic        bufen_status,
  output logic [$clog2(PAGE_BYTES/(WORD_W/8)+1)-1:0] fill_words,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi
);
  localparam int LENW = $clog2(PAGE_BYTES + ADDR_BYTES_MAX + 2);
  localparam int IW   = $clog2(PAGE_BYTES);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [7:0]  opcode, single_byte, pb_byte, cur_byte;
  logic [ADDR_BYTES_MAX*8-1:0] addr_bytes;
  logic        wide, ack, go, push, active, done;
  logic [WORD_W-1:0] push_word;
  frame_cfg_t  cfg_q, cfg_in;
  logic [LENW-1:0] idx, alen;
  logic [IW-1:0]   data_idx;
  logic [1:0]      asel;

  spp_regs #(.ACK_LAT(ACK_LAT)) u_regs (
    .clk(clk), .rst_n(rst_i), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .opcode(opcode), .addr_bytes(addr_bytes), .wide(wide),
    .single_byte(single_byte), .buf_ack(ack), .go(go), .push(push),
    .push_word(push_word)
  );

  spp_pagebuf #(.WORD_W(WORD_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_i), .push(push && ack && !active),
    .push_word(push_word), .clear(done), .rd_idx(data_idx),
    .fill(fill_words), .rd_byte(pb_byte)
  );

  assign cfg_in = '{buffered: ack, wide: wide};

  spp_shifter #(.PAGE_BYTES(PAGE_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_i), .start(go && !active), .cfg_in(cfg_in),
    .byte_in(cur_byte), .active(active), .cfg(cfg_q), .byte_idx(idx),
    .done(done), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi)
  );

  assign alen     = cfg_q.wide ? LENW'(4) : LENW'(3);
  assign asel     = 2'(alen - idx);
  assign data_idx = IW'(idx - LENW'(1) - alen);

  always_comb begin
    if (idx == '0)        cur_byte = opcode;
    else if (idx <= alen) cur_byte = addr_bytes[asel*8 +: 8];
    else if (cfg_q.buffered) cur_byte = pb_byte;
    else                  cur_byte = single_byte;
  end

  assign cmd_busy     = active;
  assign bufen_status = ack;
endmodule

// File: tb/sim_spp_page_programmer.sv
`timescale 1ns/100ps
module sim_spp_page_programmer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic cmd_busy, bufen_status, spi_cs_n, spi_sck, spi_mosi;
  logic [5:0] fill_words;

  always #2.5 clk = ~clk;

  spp_page_programmer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmd_busy(cmd_busy), .bufen_status(bufen_status),
    .fill_words(fill_words), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi)
  );

  int checks = 0, fails = 0;
  logic [7:0] cap [140];
  int cap_bits = 0;

  always @(posedge spi_sck) begin
    if (!spi_cs_n && cap_bits < 140 * 8) begin
      cap[cap_bits / 8] = {cap[cap_bits / 8][6:0], spi_mosi};
      cap_bits++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_buf(input logic on);
    wr(4'd1, {31'd0, on});
    for (int i = 0; i < 20 && bufen_status !== on; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && cmd_busy; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        bufm;
    logic        a4;
    logic [7:0]  op;
    logic [31:0] addr;
    logic [5:0]  nw;
    logic [31:0] seed;
    logic [7:0]  wd;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 8'h02, 32'h77123456, 6'd32, 32'hA5A50000, 8'h00},  // R3 R4
    '{1'b1, 1'b1, 8'h12, 32'h89ABCDEF, 6'd32, 32'h12345678, 8'h00},  // R5
    '{1'b1, 1'b0, 8'h02, 32'h000000F0, 6'd5,  32'h0F0F0F0F, 8'h00},  // R9
    '{1'b1, 1'b0, 8'h02, 32'h00001000, 6'd40, 32'hDEAD0000, 8'h00},  // R8
    '{1'b0, 1'b0, 8'h02, 32'h55ABCDEF, 6'd0,  32'h0,        8'h5A},  // R7
    '{1'b0, 1'b1, 8'h12, 32'h01020304, 6'd0,  32'h0,        8'hC3}   // R7 R5
  };

  function automatic logic [31:0] word_val(logic [31:0] seed, int i);
    return seed ^ (32'h01030507 * 32'(i + 1));
  endfunction

  function automatic logic [7:0] exp_byte(vec_t v, int j);
    int alen, d, w, nw;
    logic [31:0] wv;
    alen = v.a4 ? 4 : 3;
    if (j == 0) return v.op;
    if (j <= alen) return v.addr[8*(alen-j) +: 8];
    if (!v.bufm) return v.wd;
    d = j - 1 - alen;
    w = d / 4;
    nw = (v.nw > 32) ? 32 : int'(v.nw);
    if (w >= nw) return 8'h00;
    wv = word_val(v.seed, w);
    return wv[8*(d%4) +: 8];
  endfunction

  initial begin
    repeat (20000 * 10) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "bus idle",
        {spi_cs_n, spi_sck}, 2'b10);
    chk(cmd_busy === 1'b0 && bufen_status === 1'b0 && fill_words === 6'd0,
        "R1", "status", {cmd_busy, bufen_status, fill_words}, 0);

    // R8 push ignored while buffer mode is off
    wr(4'd9, 32'h11111111);
    chk(fill_words === 6'd0, "R8", "push while off", fill_words, 0);

    // R2 readback latency
    wr(4'd1, 32'h1);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 3) chk(bufen_status === 1'b0, "R2", "early readback", bufen_status, 0);
      if (i == 4) chk(bufen_status === 1'b1, "R2", "readback on time", bufen_status, 1);
    end

    // vector table: frames in several modes
    for (int v = 0; v < 6; v++) begin
      int nbytes, bad, nexp;
      vec_t t;
      t = VEC[v];
      set_buf(t.bufm);
      wr(4'd2, {24'd0, t.op});
      for (int b = 0; b < 4; b++) wr(4'd3 + 4'(b), {24'd0, t.addr[8*b +: 8]});
      wr(4'd7, {27'd0, t.a4, 4'd0});
      wr(4'd8, {24'd0, t.wd});
      for (int k = 0; k < int'(t.nw); k++) wr(4'd9, word_val(t.seed, k));
      nexp = !t.bufm ? 0 : ((t.nw > 32) ? 32 : int'(t.nw));
      chk(fill_words === 6'(nexp), "R3 R8", "fill before go", fill_words, nexp);
      cap_bits = 0;
      wr(4'd0, 32'h10);
      chk(cmd_busy === 1'b1 && spi_cs_n === 1'b0, "R6", "busy after go",
          {cmd_busy, spi_cs_n}, 2'b10);
      wait_idle();
      repeat (2) @(negedge clk);
      nbytes = 1 + (t.a4 ? 4 : 3) + (t.bufm ? 128 : 1);
      chk(cap_bits == nbytes * 8, t.bufm ? "R4" : "R7", "frame bit count",
          cap_bits, nbytes * 8);
      bad = -1;
      for (int j = 0; j < nbytes && j < 140; j++)
        if (bad < 0 && cap[j] !== exp_byte(t, j)) bad = j;
      chk(bad < 0, t.a4 ? "R5" : (t.nw < 32 && t.bufm ? "R9" : "R4"),
          $sformatf("frame byte %0d", bad), (bad < 0) ? 0 : cap[bad],
          (bad < 0) ? 0 : exp_byte(t, bad));
      chk(fill_words === 6'd0 && spi_cs_n === 1'b1 && cmd_busy === 1'b0,
          "R10", "idle after frame", {fill_words, spi_cs_n, cmd_busy}, 8'h02);
    end

    // R6 + R10: go rewritten mid-frame, pushes held across the final cycle
    begin
      int expn, nbusy, nidle;
      logic b;
      set_buf(1'b1);
      wr(4'd7, 32'h0);
      for (int k = 0; k < 3; k++) wr(4'd9, 32'hCAFE0000 + 32'(k));
      cap_bits = 0;
      wr(4'd0, 32'h10);
      repeat (100) @(negedge clk);
      wr(4'd0, 32'h10);
      repeat (1990) @(negedge clk);
      expn = 0; nbusy = 0; nidle = 0;
      for (int i = 0; i < 60; i++) begin
        b = cmd_busy;
        if (b) nbusy++; else nidle++;
        if (!b && expn < 32) expn++;
        reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 32'h0 + 32'(i);
        @(negedge clk);
      end
      reg_we = 1'b0;
      chk(nbusy > 0 && nidle > 0, "R10", "window spans frame end", nbusy, nidle);
      chk(fill_words === 6'(expn), "R10", "fill after collision", fill_words, expn);
      repeat (20) @(negedge clk);
      chk(cap_bits == 132 * 8 && cmd_busy === 1'b0, "R6", "mid-frame go ignored",
          cap_bits, 132 * 8);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule